// File: doc/BRIEF.md
# Instruction Fetch Translation Cache

This block translates instruction fetch addresses through a small fully associative cache of four page entries. It sits in front of a larger unified translation table, which is reached only through a request/response port. A fetch that matches exactly one cached entry is answered from the cache. A fetch that matches no cached entry sends one request to the unified table. The returned entry is written into the least recently used slot and the match is tried once more.

Matching follows the unified table's rules. There are four page sizes: 1 KiB, 4 KiB, 64 KiB and 1 MiB. Address space identifiers are compared unless the entry is shared, or unless the fetch is privileged and the identifier bypass is enabled. Recency is held as six pairwise-order bits, one for each pair of slots. The victim is decoded from fixed patterns of those bits.

Each accepted fetch produces exactly one response, with one of four outcomes:
- a physical address;
- a miss;
- a multiple match;
- a privilege violation.

Top module: `ixl_fetch_xlate`

## Requirements
- R1: After reset `resp_valid` and `ut_req_valid` are low, `req_ready` is high, and the cache holds no valid entry, so the first fetch always goes to the unified table. The reset recency order, from most to least recent, is slot 0, 1, 2, 3.
- R2: Page size code 0/1/2/3 selects 1 KiB/4 KiB/64 KiB/1 MiB. The physical address is the entry's page number, shifted left by 10 and masked to the page, ORed with the fetch address bits below the page size.
- R3: An entry's identifier must equal `req_asid`, except when the entry is shared, or when `req_user` is 0 and `req_asid_bypass` is 1.
- R4: When no cached entry matches, `ut_req_valid` rises with the fetch context and holds steady until `ut_rsp_valid`. A returned entry with status 0 is written to the victim slot. The match is then retried once, with no second request.
- R5: The victim is always the least recently used slot. Every response produced by a single match marks that slot most recent, including a retry hit and a privilege-violation outcome.
- R6: A unified-table status of 1 (miss) or 2 (multiple match) is returned as `resp_status` 1 or 2, with a zero address. Cache contents and recency are left unchanged. Status 3 is treated as a miss.
- R7: Two or more cached matches give `resp_status` 2 (multiple match) with a zero address, and leave recency unchanged.
- R8: A single match in user mode (`req_user`=1) to an entry whose user-allowed bit is 0 gives `resp_status` 3 with a zero address. Otherwise a single match gives status 0.
- R9: A cache hit responds with a one-cycle `resp_valid` pulse two rising edges after the request is accepted. `req_ready` is low from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can accept a fetch |
| req_vaddr | input | 32 | Fetch virtual address |
| req_asid | input | 8 | Current address space identifier |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_asid_bypass | input | 1 | Privileged fetches ignore identifiers |
| resp_valid | output | 1 | Response pulse |
| resp_status | output | 2 | 0 ok, 1 miss, 2 multiple match, 3 privilege violation |
| resp_paddr | output | 32 | Physical address (zero unless ok) |
| ut_req_valid | output | 1 | Lookup request to the unified table |
| ut_req_vaddr | output | 32 | Address to look up |
| ut_req_asid | output | 8 | Identifier for the lookup |
| ut_req_user | output | 1 | Mode for the lookup |
| ut_req_asid_bypass | output | 1 | Bypass setting for the lookup |
| ut_rsp_valid | input | 1 | Lookup result present |
| ut_rsp_status | input | 2 | 0 hit, 1 miss, 2 multiple match |
| ut_rsp_vpn | input | 22 | Returned virtual page number (address bits 31:10) |
| ut_rsp_asid | input | 8 | Returned identifier |
| ut_rsp_ppn | input | 22 | Returned physical page number |
| ut_rsp_size | input | 2 | Returned page size code |
| ut_rsp_shared | input | 1 | Returned entry is shared |
| ut_rsp_user_ok | input | 1 | Returned entry allows user fetches |

## Verification
A corrupted recency vector shows up at the ports only on a later refill. The wrong slot is evicted, and that is seen one or more fetches later, when a page that should still be cached causes an unexpected unified-table request. A page that should have been evicted may also hit without one. A wrong cached entry appears two edges after acceptance, as a wrong address or status. The bench therefore replays eviction chains long enough to expose each recency corruption. It also checks the presence or absence of table traffic on every fetch.

// File: rtl/ixl_pkg.sv
package ixl_pkg;
    localparam int VA_W   = 32;
    localparam int PG_LSB = 10;
    localparam int VPN_W  = VA_W - PG_LSB;
    localparam int ASID_W = 8;
    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int REC_W  = WAYS * (WAYS - 1) / 2;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  ppn;
        logic [1:0]        size;
        logic              shared;
        logic              user_ok;
    } ixl_entry_t;

    typedef enum logic [1:0] {
        XS_OK    = 2'd0,
        XS_MISS  = 2'd1,
        XS_MULTI = 2'd2,
        XS_PROT  = 2'd3
    } ixl_status_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WAIT = 2'd2
    } ixl_state_e;

    // Mask keeping the page-number bits of an address for a size code.
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        int sh;
        case (sz)
            2'd0:    sh = PG_LSB;
            2'd1:    sh = PG_LSB + 2;
            2'd2:    sh = PG_LSB + 6;
            default: sh = PG_LSB + 10;
        endcase
        return {VA_W{1'b1}} << sh;
    endfunction

    // Pairwise recency: bits a slot clears on use (kept bits).
    function automatic logic [REC_W-1:0] rec_keep(input int w);
        case (w)
            0:       return 6'h07;
            1:       return 6'h39;
            2:       return 6'h3E;
            default: return 6'h3F;
        endcase
    endfunction

    // Pairwise recency: bits a slot sets on use.
    function automatic logic [REC_W-1:0] rec_set(input int w);
        case (w)
            0:       return 6'h00;
            1:       return 6'h20;
            2:       return 6'h14;
            default: return 6'h0B;
        endcase
    endfunction
endpackage

// File: rtl/ixl_match.sv
module ixl_match
    import ixl_pkg::*;
(
    input  ixl_entry_t        ents [WAYS],
    input  logic [VA_W-1:0]   vaddr,
    input  logic [ASID_W-1:0] asid,
    input  logic              user,
    input  logic              bypass,
    output logic [WAY_W-1:0]  hit_idx,
    output logic              hit_one,
    output logic              hit_many
);
    logic [WAYS-1:0] hit_vec;
    logic            ignore_id;

    assign ignore_id = !user && bypass;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [VA_W-1:0] msk;
        logic            tag_eq;
        logic            id_ok;
        assign msk        = page_mask(ents[g].size);
        assign tag_eq     = (({ents[g].vpn, {PG_LSB{1'b0}}} & msk) == (vaddr & msk));
        assign id_ok      = ents[g].shared || ignore_id || (ents[g].asid == asid);
        assign hit_vec[g] = ents[g].valid && tag_eq && id_ok;
    end

    always_comb begin
        logic [WAY_W:0] cnt;
        cnt     = '0;
        hit_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                cnt     = cnt + 1'b1;
                hit_idx = WAY_W'(i);
            end
        end
        hit_one  = (cnt == 1);
        hit_many = (cnt > 1);
    end
endmodule

// File: rtl/ixl_store.sv
module ixl_store
    import ixl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_idx,
    input  ixl_entry_t       wr_ent,
    output ixl_entry_t       ents [WAYS]
);
    ixl_entry_t ent_d [WAYS];
    ixl_entry_t ent_q [WAYS];

    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            ent_d[wr_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            ent_q <= ent_d;
        end
    end

    assign ents = ent_q;
endmodule

// File: rtl/ixl_recency.sv
module ixl_recency
    import ixl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_idx,
    output logic [REC_W-1:0] rec_vec,
    output logic [WAYS-1:0]  victim_oh,
    output logic [WAY_W-1:0] victim_idx
);
    logic [REC_W-1:0] rec_d;
    logic [REC_W-1:0] rec_q;

    always_comb begin
        rec_d = rec_q;
        if (touch) begin
            rec_d = (rec_q & rec_keep(int'(touch_idx))) | rec_set(int'(touch_idx));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    // A slot is least recent when every pair bit it owns shows the
    // opposite of the imprint left by its own use.
    for (genvar g = 0; g < WAYS; g++) begin : g_vic
        logic [REC_W-1:0] owned;
        logic [REC_W-1:0] want;
        assign owned        = ~rec_keep(g) | rec_set(g);
        assign want         = ~rec_keep(g);
        assign victim_oh[g] = ((rec_q & owned) == want);
    end

    always_comb begin
        victim_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (victim_oh[i]) victim_idx = WAY_W'(i);
        end
    end

    assign rec_vec = rec_q;
endmodule

// File: rtl/ixl_fetch_xlate.sv
module ixl_fetch_xlate
    import ixl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_user,
    input  logic              req_asid_bypass,
    output logic              resp_valid,
    output logic [1:0]        resp_status,
    output logic [VA_W-1:0]   resp_paddr,
    output logic              ut_req_valid,
    output logic [VA_W-1:0]   ut_req_vaddr,
    output logic [ASID_W-1:0] ut_req_asid,
    output logic              ut_req_user,
    output logic              ut_req_asid_bypass,
    input  logic              ut_rsp_valid,
    input  logic [1:0]        ut_rsp_status,
    input  logic [VPN_W-1:0]  ut_rsp_vpn,
    input  logic [ASID_W-1:0] ut_rsp_asid,
    input  logic [VPN_W-1:0]  ut_rsp_ppn,
    input  logic [1:0]        ut_rsp_size,
    input  logic              ut_rsp_shared,
    input  logic              ut_rsp_user_ok
);
    typedef struct packed {
        ixl_state_e        st;
        logic [VA_W-1:0]   va;
        logic [ASID_W-1:0] asid;
        logic              user;
        logic              bypass;
        logic              retried;
        logic              rsp_v;
        ixl_status_e       rsp_st;
        logic [VA_W-1:0]   rsp_pa;
    } ctl_t;

    ctl_t c_d;
    ctl_t c_q;

    ixl_entry_t       ents [WAYS];
    ixl_entry_t       fill_ent;
    ixl_entry_t       hit_ent;
    logic [WAY_W-1:0] hit_idx;
    logic             hit_one;
    logic             hit_many;
    logic             wr_en;
    logic             touch;
    logic [REC_W-1:0] rec_vec;
    logic [WAYS-1:0]  victim_oh;
    logic [WAY_W-1:0] victim_idx;
    logic [VA_W-1:0]  hit_msk;

    ixl_match u_match (
        .ents     (ents),
        .vaddr    (c_q.va),
        .asid     (c_q.asid),
        .user     (c_q.user),
        .bypass   (c_q.bypass),
        .hit_idx  (hit_idx),
        .hit_one  (hit_one),
        .hit_many (hit_many)
    );

    assign fill_ent = '{valid: 1'b1, vpn: ut_rsp_vpn, asid: ut_rsp_asid,
                        ppn: ut_rsp_ppn, size: ut_rsp_size,
                        shared: ut_rsp_shared, user_ok: ut_rsp_user_ok};

    ixl_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (victim_idx),
        .wr_ent (fill_ent),
        .ents   (ents)
    );

    ixl_recency u_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .touch_idx  (hit_idx),
        .rec_vec    (rec_vec),
        .victim_oh  (victim_oh),
        .victim_idx (victim_idx)
    );

    assign hit_ent = ents[hit_idx];
    assign hit_msk = page_mask(hit_ent.size);

    always_comb begin
        c_d       = c_q;
        c_d.rsp_v = 1'b0;
        wr_en     = 1'b0;
        touch     = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.va      = req_vaddr;
                    c_d.asid    = req_asid;
                    c_d.user    = req_user;
                    c_d.bypass  = req_asid_bypass;
                    c_d.retried = 1'b0;
                    c_d.st      = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (hit_many) begin
                    c_d.rsp_v  = 1'b1;
                    c_d.rsp_st = XS_MULTI;
                    c_d.rsp_pa = '0;
                    c_d.st     = ST_IDLE;
                end else if (hit_one) begin
                    touch     = 1'b1;
                    c_d.rsp_v = 1'b1;
                    c_d.st    = ST_IDLE;
                    if (c_q.user && !hit_ent.user_ok) begin
                        c_d.rsp_st = XS_PROT;
                        c_d.rsp_pa = '0;
                    end else begin
                        c_d.rsp_st = XS_OK;
                        c_d.rsp_pa = ({hit_ent.ppn, {PG_LSB{1'b0}}} & hit_msk)
                                   | (c_q.va & ~hit_msk);
                    end
                end else if (c_q.retried) begin
                    c_d.rsp_v  = 1'b1;
                    c_d.rsp_st = XS_MISS;
                    c_d.rsp_pa = '0;
                    c_d.st     = ST_IDLE;
                end else begin
                    c_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ut_rsp_valid) begin
                    if (ut_rsp_status == 2'd0) begin
                        wr_en       = 1'b1;
                        c_d.retried = 1'b1;
                        c_d.st      = ST_LOOK;
                    end else begin
                        c_d.rsp_v  = 1'b1;
                        c_d.rsp_st = (ut_rsp_status == 2'd2) ? XS_MULTI : XS_MISS;
                        c_d.rsp_pa = '0;
                        c_d.st     = ST_IDLE;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, rsp_st: XS_OK, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready          = (c_q.st == ST_IDLE);
    assign resp_valid         = c_q.rsp_v;
    assign resp_status        = c_q.rsp_st;
    assign resp_paddr         = c_q.rsp_pa;
    assign ut_req_valid       = (c_q.st == ST_WAIT);
    assign ut_req_vaddr       = c_q.va;
    assign ut_req_asid        = c_q.asid;
    assign ut_req_user        = c_q.user;
    assign ut_req_asid_bypass = c_q.bypass;
endmodule

// File: rtl/ixl_fetch_xlate_chk.sv
module ixl_fetch_xlate_chk
    import ixl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic [1:0]       resp_status,
    input logic [VA_W-1:0]  resp_paddr,
    input logic             ut_req_valid,
    input logic [VA_W-1:0]  ut_req_vaddr,
    input logic             ut_rsp_valid,
    input logic [WAYS-1:0]  victim_oh
);
    // R9
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4
    ut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ut_req_valid && !ut_rsp_valid) |=> (ut_req_valid && $stable(ut_req_vaddr)));

    // R4
    ut_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ut_req_valid |-> !req_ready);

    // R5
    victim_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(victim_oh) == 1);

    // R6
    err_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status != 2'd0) |-> (resp_paddr == '0));
endmodule

bind ixl_fetch_xlate ixl_fetch_xlate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_status  (resp_status),
    .resp_paddr   (resp_paddr),
    .ut_req_valid (ut_req_valid),
    .ut_req_vaddr (ut_req_vaddr),
    .ut_rsp_valid (ut_rsp_valid),
    .victim_oh    (victim_oh)
);

// File: tb/ixl_fetch_xlate_bench.sv
`timescale 1ns/1ps
module ixl_fetch_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_asid = '0;
    logic        req_user = 1'b0;
    logic        req_asid_bypass = 1'b0;
    logic        resp_valid;
    logic [1:0]  resp_status;
    logic [31:0] resp_paddr;
    logic        ut_req_valid;
    logic [31:0] ut_req_vaddr;
    logic [7:0]  ut_req_asid;
    logic        ut_req_user;
    logic        ut_req_asid_bypass;
    logic        ut_rsp_valid = 1'b0;
    logic [1:0]  ut_rsp_status = '0;
    logic [21:0] ut_rsp_vpn = '0;
    logic [7:0]  ut_rsp_asid = '0;
    logic [21:0] ut_rsp_ppn = '0;
    logic [1:0]  ut_rsp_size = '0;
    logic        ut_rsp_shared = 1'b0;
    logic        ut_rsp_user_ok = 1'b0;

    always #10 clk = ~clk;

    ixl_fetch_xlate u_ixl_fetch_xlate (.*);

    typedef struct {
        bit        v;
        bit [21:0] vpn;
        bit [7:0]  asid;
        bit [21:0] ppn;
        bit [1:0]  sz;
        bit        sh;
        bit        uok;
    } ent_t;

    ent_t itm [4];
    ent_t utab [8];
    int   ut_n = 0;
    int   lru_q [$];
    int   tests = 0;
    int   fails = 0;
    bit   busy = 1'b0;
    int   ut_wait = 0;
    int   cyc = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] mask_of(input bit [1:0] sz);
        return 32'hFFFF_FFFF << ((sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20);
    endfunction

    function automatic bit ent_hit(input ent_t e, input bit [31:0] va, input bit [7:0] asid,
                                   input bit user, input bit byp);
        bit [31:0] m = mask_of(e.sz);
        if (!e.v) return 0;
        if ((({e.vpn, 10'b0}) & m) != (va & m)) return 0;
        return e.sh || (!user && byp) || (e.asid == asid);
    endfunction

    function automatic bit [31:0] xlat(input ent_t e, input bit [31:0] va);
        bit [31:0] m = mask_of(e.sz);
        return ({e.ppn, 10'b0} & m) | (va & ~m);
    endfunction

    task automatic ut_lookup(input bit [31:0] va, input bit [7:0] asid, input bit user, input bit byp,
                             output int cnt, output int idx);
        cnt = 0;
        idx = 0;
        for (int i = 0; i < ut_n; i++) begin
            if (ent_hit(utab[i], va, asid, user, byp)) begin
                if (cnt == 0) idx = i;
                cnt++;
            end
        end
    endtask

    task automatic touch(input int w);
        for (int i = 0; i < lru_q.size(); i++) begin
            if (lru_q[i] == w) begin
                lru_q.delete(i);
                break;
            end
        end
        lru_q.push_back(w);
    endtask

    task automatic add_ut(input bit [31:0] va, input bit [1:0] sz, input bit [7:0] asid,
                          input bit [31:0] pa, input bit sh, input bit uok);
        utab[ut_n] = '{v: 1'b1, vpn: va[31:10], asid: asid, ppn: pa[31:10], sz: sz, sh: sh, uok: uok};
        ut_n++;
    endtask

    // Unified table stand-in: answers two cycles after a request appears.
    always @(negedge clk) begin
        if (ut_rsp_valid) begin
            ut_rsp_valid <= 1'b0;
        end else if (ut_req_valid) begin
            if (ut_wait == 1) begin
                int cnt;
                int idx;
                ut_lookup(ut_req_vaddr, ut_req_asid, ut_req_user, ut_req_asid_bypass, cnt, idx);
                ut_rsp_valid   <= 1'b1;
                ut_rsp_status  <= (cnt == 0) ? 2'd1 : (cnt > 1) ? 2'd2 : 2'd0;
                ut_rsp_vpn     <= utab[idx].vpn;
                ut_rsp_asid    <= utab[idx].asid;
                ut_rsp_ppn     <= utab[idx].ppn;
                ut_rsp_size    <= utab[idx].sz;
                ut_rsp_shared  <= utab[idx].sh;
                ut_rsp_user_ok <= utab[idx].uok;
                ut_wait = 0;
            end else begin
                ut_wait++;
            end
        end
    end

    // Outside a fetch nothing may come out of the block (R9).
    always @(negedge clk) begin
        if (rst_n && !busy && (resp_valid || ut_req_valid)) begin
            fails++;
            $display("FAIL R9 idle output actual=0x%0h expected=0x0", {resp_valid, ut_req_valid});
        end
    end

    task automatic fetch(input bit [31:0] va, input bit [7:0] asid, input bit user, input bit byp,
                         input string tag);
        int  hits [$];
        bit  need_ut;
        int  exp_st;
        bit [31:0] exp_pa;
        int  k;
        bit  got;
        bit  saw_ut;

        // Reference prediction.
        need_ut = 0;
        exp_pa  = '0;
        for (int i = 0; i < 4; i++) if (ent_hit(itm[i], va, asid, user, byp)) hits.push_back(i);
        if (hits.size() == 0) begin
            int cnt;
            int idx;
            need_ut = 1;
            ut_lookup(va, asid, user, byp, cnt, idx);
            if (cnt == 0) exp_st = 1;
            else if (cnt > 1) exp_st = 2;
            else begin
                int vic = lru_q[0];
                itm[vic] = utab[idx];
                hits.push_back(vic);
            end
        end
        if (hits.size() > 1) exp_st = 2;
        else if (hits.size() == 1) begin
            touch(hits[0]);
            if (user && !itm[hits[0]].uok) exp_st = 3;
            else begin
                exp_st = 0;
                exp_pa = xlat(itm[hits[0]], va);
            end
        end

        busy = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, {tag, " R9 ready"}, req_ready, 1);
        req_valid       = 1'b1;
        req_vaddr       = va;
        req_asid        = asid;
        req_user        = user;
        req_asid_bypass = byp;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        got = 0;
        saw_ut = 0;
        while (!got && k < 100) begin
            @(negedge clk);
            k++;
            if (ut_req_valid) saw_ut = 1;
            if (resp_valid) got = 1;
        end
        check(got, {tag, " response"}, got, 1);
        check(saw_ut == need_ut, {tag, " table request"}, saw_ut, need_ut);
        check(resp_status == exp_st[1:0], {tag, " status"}, resp_status, exp_st);
        check(resp_paddr == exp_pa, {tag, " address"}, resp_paddr, exp_pa);
        if (!need_ut) check(k == 1, {tag, " R9 hit latency"}, k, 1);
        @(posedge clk);
        #1;
        busy = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) itm[i] = '{default: 0};
        lru_q = '{3, 2, 1, 0};
        add_ut(32'h0040_0000, 2'd1, 8'd1, 32'h1234_5000, 0, 1); // 4 KiB
        add_ut(32'h0080_0000, 2'd0, 8'd1, 32'h0900_0400, 0, 1); // 1 KiB
        add_ut(32'h0100_0000, 2'd2, 8'd1, 32'h0A00_0000, 1, 1); // 64 KiB shared
        add_ut(32'h0200_0000, 2'd3, 8'd1, 32'h0C00_0000, 0, 0); // 1 MiB privileged
        add_ut(32'h0300_0000, 2'd1, 8'd1, 32'h0D00_0000, 0, 1);
        add_ut(32'h0040_0000, 2'd1, 8'd2, 32'h0E00_0000, 0, 1); // same page, other id
        add_ut(32'h0500_0000, 2'd1, 8'd1, 32'h0F00_0000, 0, 1);
        add_ut(32'h0500_0000, 2'd1, 8'd1, 32'h0F10_0000, 0, 1);

        busy = 1'b1;
        repeat (3) @(negedge clk);
        check(resp_valid == 0, "R1 reset resp_valid", resp_valid, 0);
        check(ut_req_valid == 0, "R1 reset ut_req_valid", ut_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1, "R1 reset req_ready", req_ready, 1);
        busy = 1'b0;

        fetch(32'h0040_0ABC, 8'd1, 1, 0, "R1 R4 first fetch refills");
        fetch(32'h0040_0FFC, 8'd1, 1, 0, "R2 4KiB hit");
        fetch(32'h0080_03F0, 8'd1, 1, 0, "R2 1KiB page");
        fetch(32'h0100_ABCD, 8'd7, 1, 0, "R3 shared ignores id");
        fetch(32'h020F_FFF0, 8'd1, 1, 0, "R8 user to privileged page");
        fetch(32'h020F_FFF0, 8'd1, 0, 0, "R2 R8 1MiB privileged ok");
        fetch(32'h0040_0010, 8'd1, 1, 0, "R5 touch oldest");
        fetch(32'h0300_0010, 8'd1, 1, 0, "R5 evict least recent");
        fetch(32'h0040_0020, 8'd1, 1, 0, "R5 kept page hits");
        fetch(32'h0080_0000, 8'd1, 1, 0, "R5 evicted page refetched");
        fetch(32'h0700_0000, 8'd1, 1, 0, "R6 table miss");
        fetch(32'h0200_0004, 8'd1, 0, 0, "R6 contents kept after miss");
        fetch(32'h0500_0000, 8'd1, 1, 0, "R6 table multiple match");
        fetch(32'h0040_0100, 8'd2, 1, 0, "R3 other id refills");
        fetch(32'h0040_0100, 8'd3, 0, 1, "R7 cached multiple match");
        fetch(32'h0300_0020, 8'd1, 1, 0, "R7 refill after multi");
        fetch(32'h0040_0200, 8'd1, 1, 0, "R7 recency unchanged by multi");
        fetch(32'h0100_0004, 8'd1, 1, 0, "R5 shared page refill");
        fetch(32'h0200_0008, 8'd1, 1, 0, "R8 user fetch again");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule